// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block watches the byte loads that a host issues to a flash-style memory and picks out fixed address/data handshakes that carry commands. A load is one pulse on an active-high write strobe. The address is taken when the strobe rises and the data when it falls. Pulses shorter than a set number of clocks are discarded as glitches. Two handshakes share their opening steps. A three-step handshake turns write protection on and opens one page window. A six-step handshake either turns protection off or requests a full-chip erase, depending on its final byte.

A load that is not a command step is passed on to the page-load logic as a write permission pulse together with its address and data. This happens only when the device may be written: protection is off, or a page window is open. The protection flag lives in storage that the sequencer reset does not touch, so the sequencer can restart without losing it. A separate storage reset stands for the factory-fresh state of that flag. The page-load logic reports the end of its load period, and the erase engine reports when it has finished.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: A strobe pulse that is sampled high on fewer than MIN_PULSE (default 3) rising clock edges is ignored entirely. A pulse of MIN_PULSE or more edges counts as one load, taken when the strobe falls.
- R2: With protection off, no page window open and no sequence in progress, a load that is not a command step raises `wr_permit` for exactly one cycle. During that cycle `wr_addr` shows the full address present while the strobe was high and `wr_data` shows the data byte.
- R3: The loads AAh at 5555h, 55h at 2AAAh and A0h at 5555h, in that order, set `prot_on` and open `page_window`. None of the three is forwarded.
- R4: While `page_window` is high, every load is forwarded and none is decoded. A `page_done` pulse closes the window and leaves `prot_on` set.
- R5: With `prot_on` high and no window open, a load that is not a command step is blocked: `wr_permit` stays low.
- R6: The six loads AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clear `prot_on`. None of the six is forwarded.
- R7: The same six-step prefix ending in 10h at 5555h raises `erase_req`. The flag stays high until `erase_done`. While it is high, every load is dropped: it is neither decoded nor forwarded.
- R8: A load that does not match the expected next step sends the decoder back to idle. That load is then treated as an ordinary load: it is forwarded when protection is off and blocked when protection is on. Later loads that would have completed the broken sequence are also ordinary loads.
- R9: Only address bits 14..0 are compared with the command addresses. Bits 16 and 15 do not affect matching.
- R10: `rst` returns the sequencer to idle and clears `page_window`, `erase_req` and `wr_permit`, but leaves `prot_on` unchanged. `nv_rst` clears `prot_on`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer, window and erase flag |
| nv_rst | input | 1 | Synchronous active-high clear of the stored protection flag |
| wr_stb | input | 1 | Write strobe, high while a load is in progress |
| addr | input | ADDR_W (17) | Load address, captured when the strobe rises |
| data | input | 8 | Load data, captured when the strobe falls |
| page_done | input | 1 | Pulse from the page-load logic: load period has ended |
| erase_done | input | 1 | Pulse from the erase engine: erase has finished |
| wr_permit | output | 1 | One-cycle pulse that forwards a load to the page-load logic |
| wr_addr | output | ADDR_W (17) | Address of the forwarded load |
| wr_data | output | 8 | Data of the forwarded load |
| erase_req | output | 1 | Chip erase requested, held until `erase_done` |
| prot_on | output | 1 | Software write protection is active |
| page_window | output | 1 | A page window opened by the protect handshake is active |

## Verification
The hardest case to reach is a sequence that breaks midway while protection is on. The bench reaches it by first running the protect handshake and then closing the window with `page_done`. It then sends a correct first step, a wrong second load, and the remaining correct steps. The outputs must then show that no window opened and that nothing was forwarded. A second hard case is the sequencer reset with protection set, which must leave `prot_on` at one. The bench also runs an erase and, while it is pending, sends a full protect handshake to show that loads are not decoded during erase.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

    localparam int CMD_AW = 15;
    localparam int BYTE_W = 8;

    localparam logic [CMD_AW-1:0] CA_ODD  = 15'h5555;
    localparam logic [CMD_AW-1:0] CA_EVEN = 15'h2AAA;

    localparam logic [BYTE_W-1:0] K_KEY1    = 8'hAA;
    localparam logic [BYTE_W-1:0] K_KEY2    = 8'h55;
    localparam logic [BYTE_W-1:0] K_LOCK    = 8'hA0;
    localparam logic [BYTE_W-1:0] K_EXTEND  = 8'h80;
    localparam logic [BYTE_W-1:0] K_UNLOCK  = 8'h20;
    localparam logic [BYTE_W-1:0] K_WIPE    = 8'h10;

    // Sequencer position: how many matching steps have been seen
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_EXT,
        SQ_XK1,
        SQ_XK2
    } seq_t;

    // Outcome of one accepted load
    typedef struct packed {
        logic fwd;
        logic set_prot;
        logic clr_prot;
        logic wipe;
    } act_t;

    function automatic logic step_hit(
        input logic [CMD_AW-1:0] a,
        input logic [BYTE_W-1:0] d,
        input logic [CMD_AW-1:0] exp_a,
        input logic [BYTE_W-1:0] exp_d
    );
        return (a == exp_a) && (d == exp_d);
    endfunction

endpackage

// File: rtl/ucd_strobe_filter.sv
module ucd_strobe_filter #(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              ld_vld,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PULSE);

    logic             stb_q;
    logic [CNT_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q   <= 1'b0;
            hi_cnt  <= '0;
            ld_vld  <= 1'b0;
            ld_addr <= '0;
            ld_data <= '0;
        end else begin
            stb_q  <= wr_stb;
            ld_vld <= 1'b0;
            if (wr_stb && !stb_q) begin
                ld_addr <= addr;
                hi_cnt  <= CNT_W'(1);
            end else if (wr_stb && (hi_cnt < MIN_C)) begin
                hi_cnt <= hi_cnt + CNT_W'(1);
            end
            if (!wr_stb && stb_q) begin
                ld_vld  <= (hi_cnt >= MIN_C);
                ld_data <= data;
                hi_cnt  <= '0;
            end
        end
    end

endmodule

// File: rtl/ucd_seq_fsm.sv
module ucd_seq_fsm
    import ucd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_vld,
    input  logic [CMD_AW-1:0] ld_addr,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic              window,
    input  logic              erasing,
    input  logic              prot,
    output act_t              act
);
    seq_t state, nxt;
    logic miss;

    always_comb begin
        act  = '0;
        nxt  = state;
        miss = 1'b0;
        if (ld_vld && !erasing) begin
            if (window) begin
                act.fwd = 1'b1;
            end else begin
                case (state)
                    SQ_IDLE: begin
                        if (step_hit(ld_addr, ld_data, CA_ODD, K_KEY1)) nxt = SQ_K1;
                        else miss = 1'b1;
                    end
                    SQ_K1: begin
                        if (step_hit(ld_addr, ld_data, CA_EVEN, K_KEY2)) nxt = SQ_K2;
                        else miss = 1'b1;
                    end
                    SQ_K2: begin
                        if (step_hit(ld_addr, ld_data, CA_ODD, K_LOCK)) begin
                            act.set_prot = 1'b1;
                            nxt = SQ_IDLE;
                        end else if (step_hit(ld_addr, ld_data, CA_ODD, K_EXTEND)) begin
                            nxt = SQ_EXT;
                        end else begin
                            miss = 1'b1;
                        end
                    end
                    SQ_EXT: begin
                        if (step_hit(ld_addr, ld_data, CA_ODD, K_KEY1)) nxt = SQ_XK1;
                        else miss = 1'b1;
                    end
                    SQ_XK1: begin
                        if (step_hit(ld_addr, ld_data, CA_EVEN, K_KEY2)) nxt = SQ_XK2;
                        else miss = 1'b1;
                    end
                    SQ_XK2: begin
                        if (step_hit(ld_addr, ld_data, CA_ODD, K_UNLOCK)) begin
                            act.clr_prot = 1'b1;
                            nxt = SQ_IDLE;
                        end else if (step_hit(ld_addr, ld_data, CA_ODD, K_WIPE)) begin
                            act.wipe = 1'b1;
                            nxt = SQ_IDLE;
                        end else begin
                            miss = 1'b1;
                        end
                    end
                    default: miss = 1'b1;
                endcase
                if (miss) begin
                    nxt     = SQ_IDLE;
                    act.fwd = !prot;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/ucd_prot_state.sv
module ucd_prot_state
    import ucd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nv_rst,
    input  act_t act,
    input  logic page_done,
    input  logic erase_done,
    output logic prot,
    output logic window,
    output logic erasing
);
    // Stored flag: only the storage clear resets it
    always_ff @(posedge clk) begin
        if (nv_rst)                     prot <= 1'b0;
        else if (!rst && act.set_prot)  prot <= 1'b1;
        else if (!rst && act.clr_prot)  prot <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            window  <= 1'b0;
            erasing <= 1'b0;
        end else begin
            if (act.set_prot)   window <= 1'b1;
            else if (page_done) window <= 1'b0;
            if (act.wipe)        erasing <= 1'b1;
            else if (erase_done) erasing <= 1'b0;
        end
    end

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
    import ucd_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nv_rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic              page_done,
    input  logic              erase_done,
    output logic              wr_permit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              erase_req,
    output logic              prot_on,
    output logic              page_window
);
    logic              ld_vld;
    logic [ADDR_W-1:0] ld_addr;
    logic [BYTE_W-1:0] ld_data;
    act_t              act;

    ucd_strobe_filter #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (BYTE_W),
        .MIN_PULSE(MIN_PULSE)
    ) u_filt (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_stb),
        .addr   (addr),
        .data   (data),
        .ld_vld (ld_vld),
        .ld_addr(ld_addr),
        .ld_data(ld_data)
    );

    ucd_seq_fsm u_seq (
        .clk    (clk),
        .rst    (rst),
        .ld_vld (ld_vld),
        .ld_addr(ld_addr[CMD_AW-1:0]),
        .ld_data(ld_data),
        .window (page_window),
        .erasing(erase_req),
        .prot   (prot_on),
        .act    (act)
    );

    ucd_prot_state u_prot (
        .clk       (clk),
        .rst       (rst),
        .nv_rst    (nv_rst),
        .act       (act),
        .page_done (page_done),
        .erase_done(erase_done),
        .prot      (prot_on),
        .window    (page_window),
        .erasing   (erase_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_permit <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_permit <= act.fwd;
            if (act.fwd) begin
                wr_addr <= ld_addr;
                wr_data <= ld_data;
            end
        end
    end

endmodule

// File: rtl/ucd_checker.sv
module ucd_checker (
    input logic clk,
    input logic rst,
    input logic nv_rst,
    input logic erase_done,
    input logic wr_permit,
    input logic erase_req,
    input logic prot_on,
    input logic page_window
);
    // R7: an erase request is held until the engine reports completion
    assert_erase_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (erase_req && !erase_done) |=> erase_req);

    // R7: nothing is forwarded while an erase is pending
    assert_no_fwd_erase_R7: assert property (@(posedge clk) disable iff (rst)
        wr_permit |-> !erase_req);

    // R3: protection turns on only together with an open page window
    assert_prot_opens_window_R3: assert property (@(posedge clk) disable iff (rst || nv_rst)
        $rose(prot_on) |-> page_window);

    // R5: a forwarded load was allowed by the state it was decided in
    assert_fwd_allowed_R5: assert property (@(posedge clk) disable iff (rst || nv_rst)
        wr_permit |-> (!$past(prot_on) || $past(page_window)));

    // R10: the sequencer reset leaves the stored protection flag alone
    assert_rst_keeps_prot_R10: assert property (@(posedge clk) disable iff (nv_rst)
        rst |=> $stable(prot_on));
endmodule

bind unlock_cmd_decoder ucd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .nv_rst     (nv_rst),
    .erase_done (erase_done),
    .wr_permit  (wr_permit),
    .erase_req  (erase_req),
    .prot_on    (prot_on),
    .page_window(page_window)
);

// File: tb/unlock_cmd_decoder_tb.sv
`timescale 1ns/1ps
module unlock_cmd_decoder_tb;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          nv_rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data = '0;
    logic          page_done = 1'b0;
    logic          erase_done = 1'b0;
    logic          wr_permit;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          erase_req;
    logic          prot_on;
    logic          page_window;

    int checks = 0;
    int errors = 0;
    int pcnt = 0;
    logic [AW-1:0] last_a = '0;
    logic [7:0]    last_d = '0;
    bit finished = 1'b0;

    unlock_cmd_decoder #(.ADDR_W(AW), .MIN_PULSE(3)) u_dut (
        .clk(clk), .rst(rst), .nv_rst(nv_rst), .wr_stb(wr_stb), .addr(addr),
        .data(data), .page_done(page_done), .erase_done(erase_done),
        .wr_permit(wr_permit), .wr_addr(wr_addr), .wr_data(wr_data),
        .erase_req(erase_req), .prot_on(prot_on), .page_window(page_window)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (wr_permit === 1'b1) begin
            pcnt   = pcnt + 1;
            last_a = wr_addr;
            last_d = wr_data;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ld(input logic [AW-1:0] a, input logic [7:0] d, input int hi);
        @(negedge clk);
        addr = a; data = d; wr_stb = 1'b1;
        repeat (hi) @(negedge clk);
        wr_stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic seq_lock();
        ld(17'h05555, 8'hAA, 3);
        ld(17'h02AAA, 8'h55, 3);
        ld(17'h05555, 8'hA0, 3);
    endtask

    task automatic seq_six(input logic [7:0] last);
        ld(17'h05555, 8'hAA, 3);
        ld(17'h02AAA, 8'h55, 3);
        ld(17'h05555, 8'h80, 3);
        ld(17'h05555, 8'hAA, 3);
        ld(17'h02AAA, 8'h55, 3);
        ld(17'h05555, last, 4);
    endtask

    task automatic pulse_page_done();
        @(negedge clk); page_done = 1'b1;
        @(negedge clk); page_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        // R10: reset state
        chk("R10 prot_on after reset", prot_on, 0);
        chk("R10 page_window after reset", page_window, 0);
        chk("R10 erase_req after reset", erase_req, 0);
        chk("R10 wr_permit after reset", wr_permit, 0);
    endtask

    task automatic t_glitch_and_plain();
        int c0 = pcnt;
        ld(17'h00123, 8'h11, 2);
        chk("R1 short pulse ignored", pcnt, c0);
        ld(17'h00123, 8'h22, 3);
        chk("R1 minimum pulse accepted", pcnt, c0 + 1);
        chk("R2 forwarded address", int'(last_a), 32'h00123);
        chk("R2 forwarded data", int'(last_d), 32'h22);
        ld(17'h1FFFF, 8'h5A, 7);
        chk("R2 second load count", pcnt, c0 + 2);
        chk("R2 full width address", int'(last_a), 32'h1FFFF);
        chk("R2 second data", int'(last_d), 32'h5A);
    endtask

    task automatic t_lock_window();
        int c0 = pcnt;
        seq_lock();
        chk("R3 steps not forwarded", pcnt, c0);
        chk("R3 prot_on set", prot_on, 1);
        chk("R3 window open", page_window, 1);
        ld(17'h05555, 8'hAA, 3);
        chk("R4 window load forwarded", pcnt, c0 + 1);
        chk("R4 window data", int'(last_d), 32'hAA);
        pulse_page_done();
        chk("R4 window closed", page_window, 0);
        chk("R4 protection kept", prot_on, 1);
        ld(17'h00200, 8'h33, 3);
        chk("R5 blocked when protected", pcnt, c0 + 1);
    endtask

    task automatic t_high_bits();
        int c0 = pcnt;
        seq_lock_high();
        chk("R9 high address bits ignored", page_window, 1);
        chk("R9 steps not forwarded", pcnt, c0);
        pulse_page_done();
    endtask

    task automatic seq_lock_high();
        ld(17'h15555, 8'hAA, 3);
        ld(17'h0AAAA, 8'h55, 3);
        ld(17'h1D555, 8'hA0, 3);
    endtask

    task automatic t_break_protected();
        int c0 = pcnt;
        ld(17'h05555, 8'hAA, 3);
        ld(17'h01234, 8'h77, 3);
        ld(17'h02AAA, 8'h55, 3);
        ld(17'h05555, 8'hA0, 3);
        chk("R8 broken sequence opens no window", page_window, 0);
        chk("R8 protected breaking load blocked", pcnt, c0);
    endtask

    task automatic t_unprotect();
        int c0 = pcnt;
        seq_six(8'h20);
        chk("R6 prot_on cleared", prot_on, 0);
        chk("R6 steps not forwarded", pcnt, c0);
        ld(17'h00400, 8'h44, 3);
        chk("R6 load after unprotect forwarded", pcnt, c0 + 1);
    endtask

    task automatic t_break_open();
        int c0 = pcnt;
        ld(17'h05555, 8'hAA, 3);
        ld(17'h00040, 8'h12, 3);
        chk("R8 unprotected breaking load forwarded", pcnt, c0 + 1);
        chk("R8 breaking load data", int'(last_d), 32'h12);
        chk("R8 protection unchanged", prot_on, 0);
    endtask

    task automatic t_erase();
        int c0 = pcnt;
        seq_six(8'h10);
        chk("R7 erase requested", erase_req, 1);
        chk("R7 steps not forwarded", pcnt, c0);
        ld(17'h00500, 8'h55, 3);
        chk("R7 load dropped during erase", pcnt, c0);
        seq_lock();
        chk("R7 no decode during erase", page_window, 0);
        chk("R7 protection unchanged during erase", prot_on, 0);
        chk("R7 request still held", erase_req, 1);
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
        @(negedge clk);
        chk("R7 erase request released", erase_req, 0);
        ld(17'h00600, 8'h66, 3);
        chk("R7 loads resume after erase", pcnt, c0 + 1);
    endtask

    task automatic t_resets();
        seq_lock();
        chk("R10 window open before rst", page_window, 1);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R10 rst keeps protection", prot_on, 1);
        chk("R10 rst closes window", page_window, 0);
        @(negedge clk); nv_rst = 1'b1;
        @(negedge clk); nv_rst = 1'b0;
        @(negedge clk);
        chk("R10 nv_rst clears protection", prot_on, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0; nv_rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_glitch_and_plain();
        t_lock_window();
        t_high_bits();
        t_break_protected();
        t_unprotect();
        t_break_open();
        t_erase();
        t_resets();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule